// File: doc/BRIEF.md
# Packet CRC-32 Inserter with End-of-Frame Disparity Correction

This block sits in a transmit byte path, ahead of line encoding. Each cycle it takes one character (eight data bits plus a control-character flag), along with start-of-packet and end-of-packet markers. Every character comes out again exactly five cycles later. Inside a packet, the last four bytes (the one carrying the end marker and the three before it) are placeholders. The block writes the CRC-32 of all earlier packet bytes over them. A test input inverts one bit of the inserted checksum, so that a far-end checker can be shown to catch it.

A mode input is sampled on each start marker. In bypass mode the packet passes untouched, for streams that are striped across lanes where a per-lane checksum is meaningless. In checksum mode the CRC is inserted. The Fibre Channel mode inserts the CRC as well, and it also follows the 8B/10B running disparity of every character it emits. If the disparity right after the checksum is positive, the end-of-frame delimiter (a K28.5 followed by a data byte) would leave the line positive. In that case the block turns a second byte of D21.4 into D21.5, or D10.4 into D10.5. Those replacement characters do not flip disparity, so the frame closes negative.

Top module: `tx_crc_stamper`

## Requirements
- R1: During reset and for the first five cycles after it, `out_data` is 0x00 and `out_k`, `out_sop` and `out_eop` are 0.
- R2: Every input character appears at the outputs exactly five cycles later. `out_k`, `out_sop` and `out_eop` are always the delayed inputs. The data byte is also unchanged unless R3, R7 or R8 says otherwise.
- R3: The checksum is CRC-32 with the reflected polynomial 0xEDB88320. The register is preset to 0xFFFFFFFF before the start-of-packet byte, bytes are processed least significant bit first, and the inserted value is the complement of the register. It covers the packet's bytes from the start marker up to the byte before the first placeholder, so a payload of ASCII "123456789" yields placeholder bytes 0x26, 0x39, 0xF4, 0xCB.
- R4: The four placeholders are the byte carrying the end marker and the three bytes before it. The least significant checksum byte replaces the earliest placeholder. A packet is at least five bytes long, so a one-byte payload is valid.
- R5: Mode encoding on `in_mode`: 2'b00 bypass, 2'b01 checksum, 2'b10 Fibre Channel, 2'b11 treated as bypass. In bypass the whole stream, placeholders included, comes out unchanged.
- R6: The mode is captured on the start-of-packet cycle. Changing `in_mode` later in the packet has no effect on that packet.
- R7: If `in_inject` is high on the cycle the end marker is presented in a checksum or Fibre Channel packet, bit 0 of the first inserted checksum byte is inverted.
- R8: Running disparity starts negative at reset and is updated from the 8B/10B rules for every emitted character. In Fibre Channel mode, suppose the end-marker byte is followed at once by K28.5 (0xBC with K flag) and then by data byte 0x95 (D21.4) or 0x8A (D10.4). If the disparity after the last checksum byte is positive, that byte is emitted as 0xB5 (D21.5) or 0xAA (D10.5). Otherwise it is left alone.
- R9: The delimiter rewrite never happens in checksum or bypass mode, or at any other position in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Input character data bits |
| in_k | input | 1 | Input character is a control character |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet (last placeholder) |
| in_mode | input | 2 | Packet mode, sampled with `in_sop` |
| in_inject | input | 1 | Corrupt the checksum of the packet ending this cycle |
| out_data | output | 8 | Output character data bits |
| out_k | output | 1 | Output control-character flag |
| out_sop | output | 1 | Delayed start marker |
| out_eop | output | 1 | Delayed end marker |

## Verification
The hardest case to reach from the ports is the delimiter rewrite. Whether it fires depends on the disparity left by the four checksum bytes, and those bytes are a hash of the payload, so no chosen payload byte sets it directly. The bench keeps its own model of checksum and disparity. For each Fibre Channel vector it walks through payload seeds until the model predicts the wanted outcome, rewrite or no rewrite, and then drives that stream. A further vector changes the mode in the middle of a packet, and another starts with control-character idles so that the disparity enters the packet in a different state.

// File: rtl/txcrc_pkg.sv
package txcrc_pkg;

    localparam int CRC_W     = 32;
    localparam int CRC_BYTES = CRC_W / 8;
    localparam int SLOT_W    = $clog2(CRC_BYTES);

    localparam logic [7:0] K28_5 = 8'hBC;
    localparam logic [7:0] D21_4 = 8'h95;
    localparam logic [7:0] D10_4 = 8'h8A;
    localparam logic [2:0] SUB5  = 3'd5;

    typedef enum logic [1:0] {
        MODE_PASS = 2'b00,
        MODE_CRC  = 2'b01,
        MODE_FC   = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        EF_IDLE      = 2'd0,
        EF_AFTER_CRC = 2'd1,
        EF_AFTER_K   = 2'd2
    } eof_st_e;

    typedef struct packed {
        logic [7:0] data;
        logic       k;
        logic       sop;
        logic       eop;
    } chr_t;

    typedef struct packed {
        chr_t              c;
        logic              pkt;
        logic              fc;
        logic              ph;
        logic [SLOT_W-1:0] slot;
        logic              bad;
    } lane_t;

    // One byte through a reflected CRC, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] cur,
                                                  input logic [7:0] d,
                                                  input logic [CRC_W-1:0] poly);
        logic [CRC_W-1:0] r;
        r = cur;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ poly;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // True when the 10-bit code of this character is unbalanced (flips RD).
    function automatic logic rd_flips(input logic [7:0] d, input logic k);
        logic f6;
        logic f4;
        case (d[4:0])
            5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16,
            5'd23, 5'd24, 5'd27, 5'd29, 5'd30, 5'd31: f6 = 1'b1;
            5'd28:                                    f6 = k;
            default:                                  f6 = 1'b0;
        endcase
        case (d[7:5])
            3'd0, 3'd4, 3'd7: f4 = 1'b1;
            default:          f4 = 1'b0;
        endcase
        return f6 ^ f4;
    endfunction

endpackage

// File: rtl/txcrc_align.sv
module txcrc_align
    import txcrc_pkg::*;
#(
    parameter int TAIL = CRC_BYTES
) (
    input  logic  clk,
    input  logic  rst,
    input  chr_t  in_c,
    input  mode_e in_mode,
    input  logic  in_inject,
    output lane_t tail_o
);

    logic  open_q, fc_q;
    logic  start, pkt_now, fc_now, close;
    lane_t entry;
    lane_t st [TAIL];

    always_comb begin
        start   = in_c.sop && (in_mode == MODE_CRC || in_mode == MODE_FC);
        pkt_now = start || open_q;
        fc_now  = start ? (in_mode == MODE_FC) : fc_q;
        close   = pkt_now && in_c.eop;
        entry.c    = in_c;
        entry.pkt  = pkt_now;
        entry.fc   = fc_now;
        entry.ph   = close;
        entry.slot = SLOT_W'(TAIL - 1);
        entry.bad  = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            fc_q   <= 1'b0;
        end else begin
            open_q <= pkt_now && !in_c.eop;
            fc_q   <= fc_now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st[0] <= '0;
        else     st[0] <= entry;
    end

    // When the end marker arrives, the stages holding the three previous
    // packet bytes are tagged with their checksum slot as they advance.
    for (genvar j = 1; j < TAIL; j++) begin : g_stage
        logic mark;
        assign mark = close && st[j-1].pkt;
        always_ff @(posedge clk) begin
            if (rst) begin
                st[j] <= '0;
            end else begin
                st[j]      <= st[j-1];
                st[j].ph   <= st[j-1].ph || mark;
                st[j].slot <= mark ? SLOT_W'(TAIL - 1 - j) : st[j-1].slot;
                st[j].bad  <= (mark && j == TAIL - 1) ? in_inject : st[j-1].bad;
            end
        end
    end

    assign tail_o = st[TAIL-1];

    // The end-marker byte always leaves as the final checksum slot.
    p_eop_last_slot_r4: assert property (@(posedge clk) disable iff (rst)
        (tail_o.ph && tail_o.c.eop) |-> (tail_o.slot == SLOT_W'(TAIL - 1)));

    // Checksum slots leave in ascending order on consecutive cycles.
    p_slot_order_r4: assert property (@(posedge clk) disable iff (rst)
        (tail_o.ph && tail_o.slot != SLOT_W'(TAIL - 1))
        |=> (tail_o.ph && tail_o.slot == $past(tail_o.slot) + 1'b1));

endmodule

// File: rtl/txcrc_acc.sv
module txcrc_acc
    import txcrc_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 32'hEDB88320,
    parameter logic [CRC_W-1:0] SEED = 32'hFFFFFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic             reseed,
    input  logic [7:0]       byte_i,
    output logic [CRC_W-1:0] fcs_o
);

    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst)      crc_q <= SEED;
        else if (upd) crc_q <= crc_byte(reseed ? SEED : crc_q, byte_i, POLY);
    end

    assign fcs_o = ~crc_q;

    // While placeholders stream out, the accumulated value must not move.
    p_hold_during_tail_r3: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(crc_q));

endmodule

// File: rtl/txcrc_rdfix.sv
module txcrc_rdfix
    import txcrc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  chr_t pick,
    input  logic arm,
    output chr_t out_o
);

    eof_st_e st_q, st_d;
    logic    rd_q;
    logic    fire;
    chr_t    o;

    always_comb begin
        o    = pick;
        fire = 1'b0;
        if (st_q == EF_AFTER_K && !pick.k &&
            (pick.data == D21_4 || pick.data == D10_4) && !rd_q) begin
            o.data[7:5] = SUB5;
            fire        = 1'b1;
        end
        st_d = EF_IDLE;
        if (arm) begin
            st_d = EF_AFTER_CRC;
        end else if (st_q == EF_AFTER_CRC && pick.k && pick.data == K28_5) begin
            st_d = EF_AFTER_K;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= EF_IDLE;
            rd_q  <= 1'b0;
            out_o <= '0;
        end else begin
            st_q  <= st_d;
            rd_q  <= rd_q ^ rd_flips(o.data, o.k);
            out_o <= o;
        end
    end

    // A rewritten delimiter leaves the line at negative disparity.
    p_fix_ends_negative_r8: assert property (@(posedge clk) disable iff (rst)
        fire |=> !rd_q);

    // A rewrite only follows a control character emitted the cycle before.
    p_fix_after_comma_r9: assert property (@(posedge clk) disable iff (rst)
        fire |-> (out_o.k && out_o.data == K28_5));

endmodule

// File: rtl/tx_crc_stamper.sv
module tx_crc_stamper
    import txcrc_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 32'hEDB88320,
    parameter logic [CRC_W-1:0] SEED = 32'hFFFFFFFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_k,
    input  logic       in_sop,
    input  logic       in_eop,
    input  logic [1:0] in_mode,
    input  logic       in_inject,
    output logic [7:0] out_data,
    output logic       out_k,
    output logic       out_sop,
    output logic       out_eop
);

    localparam int LAT   = CRC_BYTES + 1;
    localparam int CNT_W = $clog2(LAT + 1);

    chr_t             in_c, pick, out_c;
    lane_t            tail;
    logic [CRC_W-1:0] fcs;
    logic             arm;

    assign in_c = '{data: in_data, k: in_k, sop: in_sop, eop: in_eop};

    txcrc_align #(.TAIL(CRC_BYTES)) u_align (
        .clk       (clk),
        .rst       (rst),
        .in_c      (in_c),
        .in_mode   (mode_e'(in_mode)),
        .in_inject (in_inject),
        .tail_o    (tail)
    );

    txcrc_acc #(.POLY(POLY), .SEED(SEED)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .upd    (tail.pkt && !tail.ph),
        .reseed (tail.c.sop),
        .byte_i (tail.c.data),
        .fcs_o  (fcs)
    );

    always_comb begin
        pick = tail.c;
        if (tail.pkt && tail.ph)
            pick.data = fcs[8*tail.slot +: 8] ^ {7'b0, tail.bad};
        arm = tail.pkt && tail.fc && tail.ph && tail.slot == SLOT_W'(CRC_BYTES - 1);
    end

    txcrc_rdfix u_fix (
        .clk   (clk),
        .rst   (rst),
        .pick  (pick),
        .arm   (arm),
        .out_o (out_c)
    );

    assign out_data = out_c.data;
    assign out_k    = out_c.k;
    assign out_sop  = out_c.sop;
    assign out_eop  = out_c.eop;

    // Cycles since reset, saturating at the latency, to gate $past checks.
    logic [CNT_W-1:0] since_q;
    always_ff @(posedge clk) begin
        if (rst)                       since_q <= '0;
        else if (since_q != CNT_W'(LAT)) since_q <= since_q + 1'b1;
    end

    p_k_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (since_q == CNT_W'(LAT)) |-> (out_k == $past(in_k, LAT)));
    p_sop_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (since_q == CNT_W'(LAT)) |-> (out_sop == $past(in_sop, LAT)));
    p_eop_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (since_q == CNT_W'(LAT)) |-> (out_eop == $past(in_eop, LAT)));
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        (since_q < CNT_W'(LAT)) |-> (out_data == 8'h00 && !out_k && !out_sop && !out_eop));

endmodule

// File: tb/tx_crc_stamper_tb.sv
module tx_crc_stamper_tb;

    localparam int CLK_NS = 10;
    localparam int MAXN   = 128;
    localparam int NCASE  = 10;

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] len;
        logic [7:0] seed;
        logic       alt;
        logic       inject;
        logic       want;
        logic       mid;
        logic       kidle;
    } case_t;

    // mode, payload length, seed, D10.4 delimiter, inject, want rewrite, mid-switch, K idles
    localparam case_t CASES [NCASE] = '{
        '{2'b01, 8'd9,  8'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{2'b01, 8'd1,  8'd5,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{2'b01, 8'd40, 8'd9,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'b00, 8'd12, 8'd3,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'b10, 8'd20, 8'd7,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{2'b10, 8'd17, 8'd11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{2'b10, 8'd23, 8'd13, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{2'b01, 8'd10, 8'd17, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{2'b10, 8'd14, 8'd19, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{2'b11, 8'd6,  8'd23, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] in_data = 8'h00;
    logic in_k = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_inject = 1'b0;
    logic [1:0] in_mode = 2'b00;
    logic [7:0] out_data;
    logic out_k, out_sop, out_eop;

    int total = 0;
    int bad   = 0;

    logic [7:0] s_d [MAXN];
    logic       s_k [MAXN];
    logic       s_s [MAXN];
    logic       s_e [MAXN];
    logic [1:0] s_m [MAXN];
    logic       s_i [MAXN];
    logic [7:0] e_d [MAXN];
    logic [7:0] g_d [MAXN];
    string      tg  [MAXN];
    int         n_chr;
    int         sop_i;
    int         eop_i;

    always #(CLK_NS/2) clk = ~clk;

    tx_crc_stamper u_dut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_k(in_k), .in_sop(in_sop),
        .in_eop(in_eop), .in_mode(in_mode), .in_inject(in_inject),
        .out_data(out_data), .out_k(out_k), .out_sop(out_sop), .out_eop(out_eop)
    );

    function automatic logic [31:0] m_crc(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c;
        for (int b = 0; b < 8; b++) begin
            logic fb = r[0] ^ d[b];
            r = {1'b0, r[31:1]};
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    function automatic logic m_flip(input logic [7:0] d, input logic k);
        logic [31:0] m5 = 32'hE9818117;
        logic [7:0]  m3 = 8'h91;
        logic f6 = m5[d[4:0]] | (k && d[4:0] == 5'd28);
        return f6 ^ m3[d[7:5]];
    endfunction

    function automatic logic [7:0] pay(input int sd, input int i);
        if (sd == 0) return 8'(8'h31 + i);
        return 8'(sd * 37 + i * 53 + i * i * 7);
    endfunction

    task automatic push(input logic [7:0] d, input logic k, input logic s, input logic e,
                        input logic [1:0] m);
        s_d[n_chr] = d; s_k[n_chr] = k; s_s[n_chr] = s; s_e[n_chr] = e;
        s_m[n_chr] = m; s_i[n_chr] = 1'b0;
        n_chr++;
    endtask

    // Builds stimulus and expected output for one vector; reports whether the
    // model rewrote the delimiter.
    task automatic build(input case_t c, input int sd, output logic fixed);
        logic [7:0]  idle_d = c.kidle ? 8'hBC : 8'h4A;
        logic        act    = (c.mode == 2'b01 || c.mode == 2'b10);
        logic [31:0] crc    = 32'hFFFFFFFF;
        logic        rd     = 1'b0;
        logic        rd_end = 1'b0;
        n_chr = 0;
        fixed = 1'b0;
        for (int i = 0; i < 3; i++) push(idle_d, c.kidle, 1'b0, 1'b0, c.mode);
        sop_i = n_chr;
        for (int i = 0; i < int'(c.len); i++) push(pay(sd, i), 1'b0, i == 0, 1'b0, c.mode);
        for (int i = 0; i < 4; i++) push(8'hEE, 1'b0, 1'b0, i == 3, c.mode);
        eop_i = n_chr - 1;
        s_i[eop_i] = c.inject;
        push(8'hBC, 1'b1, 1'b0, 1'b0, c.mode);
        push(c.alt ? 8'h8A : 8'h95, 1'b0, 1'b0, 1'b0, c.mode);
        for (int i = 0; i < 4; i++) push(idle_d, c.kidle, 1'b0, 1'b0, c.mode);
        if (c.mid)
            for (int i = sop_i + 1; i < n_chr; i++) s_m[i] = 2'b00;
        for (int i = 0; i < n_chr; i++) begin
            logic [7:0] d = s_d[i];
            tg[i] = c.mid ? "R6" : "R2";
            if (act && i >= sop_i && i < sop_i + int'(c.len)) crc = m_crc(crc, d);
            if (act && i > eop_i - 4 && i <= eop_i) begin
                int sl = i - (eop_i - 3);
                logic [31:0] f = ~crc;
                d = f[8*sl +: 8];
                if (sl == 0 && c.inject) begin d[0] = ~d[0]; tg[i] = "R7"; end
                else if (!c.mid) tg[i] = (c.len == 1) ? "R4" : "R3";
            end
            if (!act && !c.mid) tg[i] = "R5";
            if (i == eop_i + 2) begin
                if (!c.mid) tg[i] = (c.mode == 2'b10) ? "R8" : "R9";
                if (c.mode == 2'b10 && rd_end) begin
                    d[7:5] = 3'd5;
                    fixed  = 1'b1;
                end
            end
            e_d[i] = d;
            rd = rd ^ m_flip(d, s_k[i]);
            if (i == eop_i) rd_end = rd;
        end
    endtask

    task automatic check(input string t, input int idx,
                         input logic [10:0] got, input logic [10:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s idx=%0d got=%h exp=%h", t, idx, got, exp);
        end
    endtask

    task automatic run_case(input case_t c);
        logic fixed;
        int   sd = int'(c.seed);
        build(c, sd, fixed);
        if (c.mode == 2'b10) begin
            for (int tr = 1; tr < 64 && fixed != c.want; tr++) begin
                sd = int'(c.seed) + 3 * tr;
                build(c, sd, fixed);
            end
        end
        rst = 1'b1;
        in_data = 8'h00; in_k = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        in_inject = 1'b0; in_mode = 2'b00;
        repeat (3) @(negedge clk);
        for (int t = 0; t < n_chr + 5; t++) begin
            @(negedge clk);
            if (t < 5) begin
                check("R1", t, {out_data, out_k, out_sop, out_eop}, 11'h000);
            end else begin
                int j = t - 5;
                g_d[j] = out_data;
                check(tg[j], j, {out_data, out_k, out_sop, out_eop},
                      {e_d[j], s_k[j], s_s[j], s_e[j]});
            end
            rst = 1'b0;
            if (t < n_chr) begin
                in_data = s_d[t]; in_k = s_k[t]; in_sop = s_s[t]; in_eop = s_e[t];
                in_mode = s_m[t]; in_inject = s_i[t];
            end else begin
                in_data = 8'h4A; in_k = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
                in_inject = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R2 watchdog got=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int ci = 0; ci < NCASE; ci++) begin
            run_case(CASES[ci]);
            if (ci == 0) begin
                // R3 known answer for the payload "123456789"
                check("R3", 0, {g_d[12], 3'b0}, {8'h26, 3'b0});
                check("R3", 1, {g_d[13], 3'b0}, {8'h39, 3'b0});
                check("R3", 2, {g_d[14], 3'b0}, {8'hF4, 3'b0});
                check("R3", 3, {g_d[15], 3'b0}, {8'hCB, 3'b0});
            end
            if (ci == 4 || ci == 5) begin
                // R8: the delimiter was actually rewritten on the wire
                check("R8", eop_i + 2, {g_d[eop_i + 2], 3'b0},
                      {(CASES[ci].alt ? 8'hAA : 8'hB5), 3'b0});
            end
            if (ci == 7) begin
                // R9: checksum mode leaves the delimiter byte alone
                check("R9", eop_i + 2, {g_d[eop_i + 2], 3'b0}, {8'h95, 3'b0});
            end
        end
        // R1: reset asserted mid-stream clears the outputs
        rst = 1'b1;
        @(negedge clk);
        check("R1", 0, {out_data, out_k, out_sop, out_eop}, 11'h000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule